// File: doc/BRIEF.md
# Card Configuration Register Block

This block is the attribute-space front end of a removable ATA storage card. A host reaches it over a byte-wide register port with separate read and write strobes. Attribute addresses below a programmable configuration base are passed through to an external configuration-information ROM. Reads in that window return the ROM byte, or zero once the address is past the ROM length. At and above the base sit four byte registers: an option register, a configuration status register, a pin replacement register and a socket/copy register.

The block holds the card's option (address-mode) field, the status flags (interrupt pending, power-down and the writable control bits), the card-ready and ready pin flags, and the gated active-low interrupt request. The interrupt request follows the documented inverted sense: it is active while the status interrupt bit is clear. A separate address decoder takes the mode field, the interrupt-enable and soft-reset bits of its device control register, and a card reset pulse from this block. It can also ask this block for a card reset.

Both the request and the response are single-cycle strobes with no back-pressure. The block accepts every access in the cycle it is presented. A read returns its byte one cycle later with `bus_rvalid`. At most one of `bus_rd` and `bus_wr` is high in a cycle.

Top module: `cardcfg_regs`

## Requirements
- R1: A read at an address below `cfg_base` returns `rom_data` for `rom_addr` = `bus_addr` when the address is below ROM_LEN, and 0x00 otherwise; every read answers on `bus_rdata` with `bus_rvalid` high exactly one cycle after `bus_rd`.
- R2: A write to offset 0x00 from the base (option register) without bit 7 set stores the value ANDed with 0xCF. A read returns the stored value, and `mode` shows its bits 5:0.
- R3: A write to the option register with bit 7 set resets the card state. Option, status, pin flags and `pin_rdy` become zero, and `ata_rst` is high for exactly the cycle after the write.
- R4: A write to offset 0x02 (configuration status) keeps the stored bits under mask 0x82 and loads the written bits under mask 0x74; bit 1 then follows `dev_irq`.
- R5: When bit 2 (power-down) of a status write differs from the stored bit 2, the sticky card-ready flag (pin register bit 5, 0x20) is set; a status write that leaves bit 2 unchanged does not set it.
- R6: A status read returns the stored status, with bit 1 (0x02) cleared in the returned value while `ctl_ien` is high.
- R7: A read of offset 0x04 (pin replacement) returns (card-ready << 5) | 0x0C. A write there loads bit 1 into `pin_rdy` and leaves card-ready unchanged.
- R8: Offset 0x06 (socket/copy) and every other offset at or above the base read as 0x00, and writes to them change no register.
- R9: `irq_n` is low exactly when status bit 1 is clear, `ctl_ien` is low, `ctl_srst` is low and option bit 7 is clear.
- R10: Status bit 1 takes the value of `dev_irq` at each clock edge, so a change on `dev_irq` shows in the status and in `irq_n` one cycle later.
- R11: A one-cycle `ctl_rst_req` performs the same card reset as R3, including the `ata_rst` pulse.
- R12: The register window moves with `cfg_base`, and addresses below the new base are served from the ROM port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Attribute read strobe |
| bus_wr | input | 1 | Attribute write strobe |
| bus_addr | input | AW | Attribute byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after bus_rd |
| cfg_base | input | AW | Start of the register window |
| rom_addr | output | AW | Information ROM address |
| rom_data | input | 8 | Information ROM byte for rom_addr |
| dev_irq | input | 1 | Device-side interrupt level |
| ctl_ien | input | 1 | Interrupt-enable bit of device control |
| ctl_srst | input | 1 | Soft-reset bit of device control |
| ctl_rst_req | input | 1 | Card reset request from the decoder |
| irq_n | output | 1 | Gated interrupt request, active low |
| mode | output | 6 | Option register address-mode field |
| pin_rdy | output | 1 | Ready bit of the pin replacement register |
| ata_rst | output | 1 | One-cycle reset pulse for the ATA register file |

## Verification
Status writes are tried with bit 2 flipped and with it held. This separates the sticky card-ready update from the plain keep-and-load merge. Status reads are repeated with `dev_irq` high under both settings of `ctl_ien`, which separates the readback mask from the stored bit. The interrupt output is stepped through each gating input in turn. Option writes with and without bit 7, and a separate `ctl_rst_req` pulse, show that both reset paths clear every register. Reads around the ROM length and the base, before and after the base moves, separate the ROM, zero and register windows.

// File: rtl/cardcfg_pkg.sv
package cardcfg_pkg;

  localparam int unsigned OFS_OPT  = 0;
  localparam int unsigned OFS_STAT = 2;
  localparam int unsigned OFS_PIN  = 4;

  localparam logic [7:0] OPT_STORE_MASK = 8'hCF;
  localparam logic [7:0] STAT_KEEP_MASK = 8'h82;
  localparam logic [7:0] STAT_LOAD_MASK = 8'h74;
  localparam logic [7:0] PIN_FIXED      = 8'h0C;

  localparam int unsigned BIT_INT   = 1;
  localparam int unsigned BIT_PWR   = 2;
  localparam int unsigned BIT_RESET = 7;
  localparam int unsigned BIT_CRDY  = 5;
  localparam int unsigned BIT_RDY   = 1;

  typedef enum logic [2:0] {
    SEL_ZERO = 3'd0,
    SEL_ROM  = 3'd1,
    SEL_OPT  = 3'd2,
    SEL_STAT = 3'd3,
    SEL_PIN  = 3'd4
  } acc_sel_e;

endpackage

// File: rtl/cardcfg_state.sv
module cardcfg_state
  import cardcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  acc_sel_e   sel,
  input  logic [7:0] wdata,
  input  logic       dev_irq,
  input  logic       ctl_rst_req,
  output logic [7:0] opt_q,
  output logic [7:0] stat_q,
  output logic       crdy_q,
  output logic       rdy_q,
  output logic       card_rst
);

  logic wr_opt, wr_stat, wr_pin;
  logic [7:0] stat_nx;

  assign wr_opt   = wr_en && (sel == SEL_OPT);
  assign wr_stat  = wr_en && (sel == SEL_STAT);
  assign wr_pin   = wr_en && (sel == SEL_PIN);
  assign card_rst = ctl_rst_req || (wr_opt && wdata[BIT_RESET]);

  always_comb begin
    stat_nx = stat_q;
    if (wr_stat) stat_nx = (stat_q & STAT_KEEP_MASK) | (wdata & STAT_LOAD_MASK);
    stat_nx[BIT_INT] = dev_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q  <= '0;
      stat_q <= '0;
      crdy_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else if (card_rst) begin
      opt_q  <= '0;
      stat_q <= '0;
      crdy_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      if (wr_opt) opt_q <= wdata & OPT_STORE_MASK;
      stat_q <= stat_nx;
      if (wr_stat && (stat_q[BIT_PWR] != wdata[BIT_PWR])) crdy_q <= 1'b1;
      if (wr_pin) rdy_q <= wdata[BIT_RDY];
    end
  end

  // R5: card-ready is sticky until a card reset
  p_crdy_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (crdy_q && !card_rst) |=> crdy_q);

  // R10: interrupt bit samples the device level
  p_int_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !card_rst |=> (stat_q[BIT_INT] == $past(dev_irq)));

  // R3 / R11: a card reset empties every register
  p_reset_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> (opt_q == 8'h00 && stat_q == 8'h00 && !crdy_q && !rdy_q));

  // R4: bit 7 of status is never loaded from a write
  p_stat_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !card_rst) |=> (stat_q[7] == $past(stat_q[7])));

endmodule

// File: rtl/cardcfg_rdmux.sv
module cardcfg_rdmux
  import cardcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  acc_sel_e   sel,
  input  logic [7:0] rom_data,
  input  logic [7:0] opt_q,
  input  logic [7:0] stat_q,
  input  logic       crdy_q,
  input  logic       ien,
  output logic [7:0] rdata,
  output logic       rvalid
);

  logic [7:0] rd_nx;
  logic [7:0] stat_view;

  always_comb begin
    stat_view = stat_q;
    if (ien) stat_view[BIT_INT] = 1'b0;
    unique case (sel)
      SEL_ROM:  rd_nx = rom_data;
      SEL_OPT:  rd_nx = opt_q;
      SEL_STAT: rd_nx = stat_view;
      SEL_PIN:  rd_nx = PIN_FIXED | (8'(crdy_q) << BIT_CRDY);
      default:  rd_nx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_nx;
    end
  end

  // R1: one response per read, one cycle later
  p_rvalid_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  p_rvalid_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

endmodule

// File: rtl/cardcfg_regs.sv
module cardcfg_regs
  import cardcfg_pkg::*;
#(
  parameter int unsigned AW      = 10,
  parameter int unsigned ROM_LEN = 330
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          bus_rvalid,
  input  logic [AW-1:0] cfg_base,
  output logic [AW-1:0] rom_addr,
  input  logic [7:0]    rom_data,
  input  logic          dev_irq,
  input  logic          ctl_ien,
  input  logic          ctl_srst,
  input  logic          ctl_rst_req,
  output logic          irq_n,
  output logic [5:0]    mode,
  output logic          pin_rdy,
  output logic          ata_rst
);

  localparam int unsigned OFS_W = AW;

  acc_sel_e          sel;
  logic [OFS_W-1:0]  ofs;
  logic [7:0]        opt_q, stat_q;
  logic              crdy_q, card_rst, ata_rst_q;

  assign ofs      = bus_addr - cfg_base;
  assign rom_addr = bus_addr;

  always_comb begin
    if (bus_addr < cfg_base) begin
      sel = (32'(bus_addr) < ROM_LEN) ? SEL_ROM : SEL_ZERO;
    end else if (ofs == OFS_W'(OFS_OPT)) begin
      sel = SEL_OPT;
    end else if (ofs == OFS_W'(OFS_STAT)) begin
      sel = SEL_STAT;
    end else if (ofs == OFS_W'(OFS_PIN)) begin
      sel = SEL_PIN;
    end else begin
      sel = SEL_ZERO;
    end
  end

  cardcfg_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (bus_wr),
    .sel         (sel),
    .wdata       (bus_wdata),
    .dev_irq     (dev_irq),
    .ctl_rst_req (ctl_rst_req),
    .opt_q       (opt_q),
    .stat_q      (stat_q),
    .crdy_q      (crdy_q),
    .rdy_q       (pin_rdy),
    .card_rst    (card_rst)
  );

  cardcfg_rdmux u_rdmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_rd),
    .sel      (sel),
    .rom_data (rom_data),
    .opt_q    (opt_q),
    .stat_q   (stat_q),
    .crdy_q   (crdy_q),
    .ien      (ctl_ien),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  // Inverted sense: request while the device interrupt bit is clear
  assign irq_n = stat_q[BIT_INT] | ctl_ien | ctl_srst | opt_q[BIT_RESET];
  assign mode  = opt_q[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ata_rst_q <= 1'b0;
    else        ata_rst_q <= card_rst;
  end
  assign ata_rst = ata_rst_q;

  // R3 / R11: every card reset is followed by the ATA reset pulse
  p_ata_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> ata_rst);

  // R9: no request while any gate input is active
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_ien || ctl_srst) |-> irq_n);

  // R2: mode field never shows the masked-out bits
  p_mode_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode[5:4] == 2'b00);

endmodule

// File: tb/sim_cardcfg_regs.sv
`timescale 1ns/1ps
module sim_cardcfg_regs;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          bus_rvalid;
  logic [AW-1:0] cfg_base = 10'h200;
  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data;
  logic          dev_irq = 1'b0, ctl_ien = 1'b0, ctl_srst = 1'b0, ctl_rst_req = 1'b0;
  logic          irq_n, pin_rdy, ata_rst;
  logic [5:0]    mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  assign rom_data = rom_addr[7:0] ^ 8'h5A;

  cardcfg_regs #(.AW(AW), .ROM_LEN(330)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cfg_base(cfg_base), .rom_addr(rom_addr),
    .rom_data(rom_data), .dev_irq(dev_irq), .ctl_ien(ctl_ien),
    .ctl_srst(ctl_srst), .ctl_rst_req(ctl_rst_req), .irq_n(irq_n),
    .mode(mode), .pin_rdy(pin_rdy), .ata_rst(ata_rst)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: pop the oldest expected byte on every response
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected response", 8'h01, 8'h00);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R9 irq_n after reset", {7'd0, irq_n}, 8'h00);
    check("R2 mode after reset", {2'd0, mode}, 8'h00);
    rd(10'h200, 8'h00, "R2 option reset value");
    rd(10'h202, 8'h00, "R4 status reset value");
    rd(10'h204, 8'h0C, "R7 pin reset value");
    // ROM window
    rd(10'h010, 8'h4A, "R1 rom byte 0x010");
    rd(10'h149, 8'h13, "R1 last rom byte");
    rd(10'h14A, 8'h00, "R1 past rom length");
    rd(10'h1FF, 8'h00, "R1 just below base");
    // option register
    wr(10'h200, 8'h4F);
    check("R2 mode after 0x4F", {2'd0, mode}, 8'h0F);
    rd(10'h200, 8'h4F, "R2 option readback 0x4F");
    wr(10'h200, 8'h73);
    rd(10'h200, 8'h43, "R2 option masked 0x73");
    check("R2 mode after 0x73", {2'd0, mode}, 8'h03);
    // status and card-ready
    wr(10'h202, 8'h00);
    rd(10'h204, 8'h0C, "R5 no toggle leaves card-ready clear");
    wr(10'h202, 8'hFF);
    rd(10'h202, 8'h74, "R4 status load mask");
    rd(10'h204, 8'h2C, "R5 power-down toggle sets card-ready");
    wr(10'h202, 8'h04);
    rd(10'h202, 8'h04, "R4 status rewrite");
    rd(10'h204, 8'h2C, "R5 card-ready sticky");
    // interrupt path
    dev_irq = 1'b1;
    @(negedge clk);
    check("R10 irq_n released by device level", {7'd0, irq_n}, 8'h01);
    rd(10'h202, 8'h06, "R10 status interrupt bit set");
    ctl_ien = 1'b1;
    rd(10'h202, 8'h04, "R6 interrupt bit masked under enable");
    wr(10'h202, 8'h00);
    rd(10'h202, 8'h00, "R4 interrupt bit kept, load bits cleared");
    ctl_ien = 1'b0;
    rd(10'h202, 8'h02, "R6 interrupt bit visible without enable");
    dev_irq = 1'b0;
    @(negedge clk);
    check("R9 irq_n asserted all gates clear", {7'd0, irq_n}, 8'h00);
    ctl_ien = 1'b1; #1;
    check("R9 irq_n gated by enable", {7'd0, irq_n}, 8'h01);
    ctl_ien = 1'b0; ctl_srst = 1'b1; #1;
    check("R9 irq_n gated by soft reset", {7'd0, irq_n}, 8'h01);
    ctl_srst = 1'b0; #1;
    check("R9 irq_n re-asserted", {7'd0, irq_n}, 8'h00);
    // pin register
    wr(10'h204, 8'hFF);
    check("R7 ready pin loaded", {7'd0, pin_rdy}, 8'h01);
    rd(10'h204, 8'h2C, "R7 pin read after write 0xFF");
    wr(10'h204, 8'h00);
    check("R7 ready pin cleared", {7'd0, pin_rdy}, 8'h00);
    rd(10'h204, 8'h2C, "R7 card-ready kept by pin write");
    // socket and unmapped
    wr(10'h206, 8'hFF);
    rd(10'h206, 8'h00, "R8 socket reads zero");
    rd(10'h200, 8'h43, "R8 socket write left option alone");
    rd(10'h202, 8'h00, "R8 socket write left status alone");
    wr(10'h20A, 8'hFF);
    rd(10'h20A, 8'h00, "R8 unmapped offset reads zero");
    rd(10'h204, 8'h2C, "R8 unmapped write left pins alone");
    // reset through option bit 7
    wr(10'h204, 8'h02);
    check("R3 ata_rst idle", {7'd0, ata_rst}, 8'h00);
    wr(10'h200, 8'hFF);
    check("R3 ata_rst pulse", {7'd0, ata_rst}, 8'h01);
    check("R3 ready pin cleared", {7'd0, pin_rdy}, 8'h00);
    @(negedge clk);
    check("R3 ata_rst one cycle", {7'd0, ata_rst}, 8'h00);
    rd(10'h200, 8'h00, "R3 option zero after reset");
    rd(10'h204, 8'h0C, "R3 card-ready cleared");
    check("R3 irq_n after reset", {7'd0, irq_n}, 8'h00);
    // reset through control request
    wr(10'h200, 8'h41);
    wr(10'h202, 8'h04);
    wr(10'h204, 8'h02);
    @(negedge clk);
    ctl_rst_req = 1'b1;
    @(negedge clk);
    ctl_rst_req = 1'b0;
    check("R11 ata_rst pulse", {7'd0, ata_rst}, 8'h01);
    check("R11 mode cleared", {2'd0, mode}, 8'h00);
    check("R11 ready pin cleared", {7'd0, pin_rdy}, 8'h00);
    @(negedge clk);
    check("R11 ata_rst one cycle", {7'd0, ata_rst}, 8'h00);
    rd(10'h202, 8'h00, "R11 status cleared");
    rd(10'h204, 8'h0C, "R11 card-ready cleared");
    // moving the base
    cfg_base = 10'h100;
    wr(10'h100, 8'h02);
    rd(10'h100, 8'h02, "R12 option at new base");
    check("R12 mode from new base", {2'd0, mode}, 8'h02);
    rd(10'h0FF, 8'hA5, "R12 rom below new base");
    rd(10'h200, 8'h00, "R12 old base now unmapped");
    repeat (3) @(negedge clk);
    check("R1 all responses seen", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule